// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the register set that a host sees for one channel of a disk-style bus-master DMA controller. It holds a command byte, a status byte and the base address of the descriptor table, and it turns host writes into control events for a separate DMA engine. That engine walks the descriptors. A start request goes out when the host sets the start bit. When the host clears that bit, a quiesce request is held until the engine reports that it is idle. The block also relays the drive's interrupt line and records an interrupt flag in status.

The host reaches the block through a simple register bus. Each access carries a byte address, a size code and 32 bits of write data. Read data comes back from a register one cycle after the read strobe. The table base accepts 1-, 2- and 4-byte writes at any byte offset. At every table start, the current table pointer is reloaded from the base and exported to the engine.

Top module: `busmaster_regfile`

## Requirements
- R1: A command write at offset 0 stores only bit 0 (start) and bit 3 (direction), that is, the written byte ANDed with 0x09, and a read of offset 0 returns that stored byte.
- R2: A command write whose start bit equals the stored start bit stores the masked byte, raises no start request and leaves the current table pointer unchanged.
- R3: A command write that changes start from 0 to 1 reloads the current table pointer from the base register and sets status bit 0 (active). The start request is a single-cycle pulse in the following cycle, and it is raised only if active was clear.
- R4: A command write that changes start from 1 to 0 while the engine is busy keeps active set and holds the quiesce request high. In the first cycle that finds the engine idle, active and quiesce are cleared, so they read low one cycle later.
- R5: A command write that changes start from 1 to 0 while the engine is idle clears active at once.
- R6: A write to the table base at offsets 4 to 7 replaces only the addressed byte lanes. The write-data byte 0 lands at the addressed lane, and lanes above 7 are dropped. Size code 0 writes 1 byte, code 1 writes 2 bytes and code 2 writes 4 bytes. Base bits 1:0 always read as zero.
- R7: A read of offsets 4 to 7 returns the base shifted down by 8 times the byte offset and masked to the access size.
- R8: A rising edge of the device interrupt sets status bit 2 (interrupt), and the interrupt output follows the device level one cycle later.
- R9: A falling device interrupt is passed to the output and leaves status bit 2 unchanged.
- R10: A pulse on the engine error input sets status bit 1 (error).
- R11: Writing 1 to status bits 1 or 2 at offset 2 clears them. Active cannot be changed by a status write.
- R12: Reset clears command, status, base, current table pointer, the pending stop and the request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte address |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| bus_rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | DMA engine has a transfer in flight |
| eng_err | input | 1 | DMA engine error pulse |
| dev_irq | input | 1 | Drive interrupt level |
| irq_out | output | 1 | Forwarded interrupt level |
| start_req | output | 1 | One-cycle request to begin a table walk |
| quiesce_req | output | 1 | Held while a stop waits for the engine |
| cur_ptr | output | 32 | Current descriptor table pointer |

## Verification
On every cycle the assertions check the following: the command byte never holds bits outside the start and direction mask, and the base never holds nonzero low bits. They also check that start and quiesce requests appear only while active is set, that active stays set while the engine is busy, and that the interrupt output and interrupt flag track the device line. Other behaviour can be shown only by the bench's scenarios. This includes byte-lane merging and shifted reads of the base, and the pointer reload on a genuine start edge but not on a repeated start. It also includes the deferred stop against the immediate stop, a restart while a stop is pending, and the write-1-to-clear status bits.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;

  localparam logic [7:0] CMD_KEEP = 8'h09;

  localparam int ST_ACTIVE = 0;
  localparam int ST_ERROR  = 1;
  localparam int ST_INT    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/bmr_cmd_ctl.sv
module bmr_cmd_ctl
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [7:0] wbyte,
  input  logic       eng_busy,
  output logic [7:0] cmd_q,
  output logic       active,
  output logic       start_req,
  output logic       quiesce_req,
  output logic       reload
);
  logic stop_wait;
  logic start_rise, start_fall;

  assign start_rise = cmd_we && wbyte[0] && !cmd_q[0];
  assign start_fall = cmd_we && !wbyte[0] && cmd_q[0];
  assign reload     = start_rise;
  assign quiesce_req = stop_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      active    <= 1'b0;
      start_req <= 1'b0;
      stop_wait <= 1'b0;
    end else begin
      start_req <= 1'b0;
      if (stop_wait && !eng_busy) begin
        active    <= 1'b0;
        stop_wait <= 1'b0;
      end
      if (cmd_we) begin
        cmd_q <= wbyte & CMD_KEEP;
      end
      if (start_rise) begin
        stop_wait <= 1'b0;
        active    <= 1'b1;
        start_req <= !active;
      end else if (start_fall) begin
        if (eng_busy) begin
          stop_wait <= 1'b1;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bmr_base_reg.sv
module bmr_base_reg
  import bmr_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_we,
  input  logic [1:0]       lane_ofs,
  input  logic [1:0]       size_code,
  input  logic [PTR_W-1:0] wdata,
  input  logic             reload,
  output logic [PTR_W-1:0] base_q,
  output logic [PTR_W-1:0] cur_ptr
);
  localparam int LANES = PTR_W / 8;

  logic [PTR_W-1:0] base_nxt;
  logic [2:0]       nb;

  assign nb = size_bytes(size_code);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] rel;
    logic       hit;
    assign rel = 2'(i) - lane_ofs;
    assign hit = base_we && (2'(i) >= lane_ofs) && ({1'b0, rel} < nb);
    if (i == 0) begin : g_low
      assign base_nxt[7:0] = hit ? {wdata[rel*8 +: 8] & 8'hFC}
                                 : base_q[7:0];
    end else begin : g_hi
      assign base_nxt[i*8 +: 8] = hit ? wdata[rel*8 +: 8] : base_q[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      cur_ptr <= '0;
    end else begin
      base_q <= base_nxt;
      if (reload) begin
        cur_ptr <= base_q;
      end
    end
  end
endmodule

// File: rtl/bmr_irq_stat.sv
module bmr_irq_stat
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dev_irq,
  input  logic       eng_err,
  input  logic       stat_we,
  input  logic [7:0] wbyte,
  output logic       irq_out,
  output logic       int_flag,
  output logic       err_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      int_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      irq_out <= dev_irq;
      if (dev_irq && !irq_out) begin
        int_flag <= 1'b1;
      end else if (stat_we && wbyte[ST_INT]) begin
        int_flag <= 1'b0;
      end
      if (eng_err) begin
        err_flag <= 1'b1;
      end else if (stat_we && wbyte[ST_ERROR]) begin
        err_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/busmaster_regfile.sv
module busmaster_regfile
  import bmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_err,
  input  logic              dev_irq,
  output logic              irq_out,
  output logic              start_req,
  output logic              quiesce_req,
  output logic [DATA_W-1:0] cur_ptr
);
  logic              cmd_we, stat_we, base_we, reload;
  logic [7:0]        cmd_q, stat_byte;
  logic              active, int_flag, err_flag;
  logic [DATA_W-1:0] base_q, shifted, size_mask;

  assign cmd_we  = bus_wr && (bus_addr == OFS_CMD);
  assign stat_we = bus_wr && (bus_addr == OFS_STAT);
  assign base_we = bus_wr && bus_addr[2];

  bmr_cmd_ctl u_cmd (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .wbyte(bus_wdata[7:0]),
    .eng_busy(eng_busy), .cmd_q(cmd_q), .active(active),
    .start_req(start_req), .quiesce_req(quiesce_req), .reload(reload)
  );

  bmr_base_reg #(.PTR_W(DATA_W)) u_base (
    .clk(clk), .rst(rst), .base_we(base_we), .lane_ofs(bus_addr[1:0]),
    .size_code(bus_size), .wdata(bus_wdata), .reload(reload),
    .base_q(base_q), .cur_ptr(cur_ptr)
  );

  bmr_irq_stat u_irq (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .eng_err(eng_err),
    .stat_we(stat_we), .wbyte(bus_wdata[7:0]), .irq_out(irq_out),
    .int_flag(int_flag), .err_flag(err_flag)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[ST_ACTIVE] = active;
    stat_byte[ST_ERROR]  = err_flag;
    stat_byte[ST_INT]    = int_flag;
    shifted = base_q >> {bus_addr[1:0], 3'b000};
    case (bus_size)
      SZ_BYTE: size_mask = DATA_W'(32'h0000_00FF);
      SZ_HALF: size_mask = DATA_W'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr[2])                  bus_rdata <= shifted & size_mask;
      else if (bus_addr == OFS_CMD)     bus_rdata <= DATA_W'(cmd_q);
      else if (bus_addr == OFS_STAT)    bus_rdata <= DATA_W'(stat_byte);
      else                              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  cmd_q,
  input logic        active,
  input logic        start_req,
  input logic        quiesce_req,
  input logic        eng_busy,
  input logic        dev_irq,
  input logic        irq_out,
  input logic        int_flag,
  input logic [31:0] base_q
);
  p_cmd_mask_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd_q & 8'hF6) == 8'h00);

  p_start_active_r3: assert property (@(posedge clk) disable iff (rst)
    start_req |-> active);

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req);

  p_quiesce_active_r4: assert property (@(posedge clk) disable iff (rst)
    quiesce_req |-> active);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (active && eng_busy) |=> active);

  p_base_low_r6: assert property (@(posedge clk) disable iff (rst)
    base_q[1:0] == 2'b00);

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    dev_irq |=> irq_out);

  p_int_set_r8: assert property (@(posedge clk) disable iff (rst)
    (dev_irq && !irq_out) |=> int_flag);

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (rst)
    !dev_irq |=> !irq_out);
endmodule

bind busmaster_regfile bmr_checker i_chk (
  .clk(clk), .rst(rst), .cmd_q(cmd_q), .active(active),
  .start_req(start_req), .quiesce_req(quiesce_req), .eng_busy(eng_busy),
  .dev_irq(dev_irq), .irq_out(irq_out), .int_flag(int_flag), .base_q(base_q)
);

// File: tb/test_busmaster_regfile.sv
module test_busmaster_regfile;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [2:0]  a;
    logic [1:0]  sz;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd4, 2'd2, 32'h1234_5677, 32'h0},
    '{1'b0, 3'd4, 2'd2, 32'h0, 32'h1234_5674},
    '{1'b1, 3'd5, 2'd0, 32'h0000_00AB, 32'h0},
    '{1'b0, 3'd4, 2'd2, 32'h0, 32'h1234_AB74},
    '{1'b1, 3'd6, 2'd1, 32'h0000_BEEF, 32'h0},
    '{1'b0, 3'd4, 2'd2, 32'h0, 32'hBEEF_AB74},
    '{1'b0, 3'd6, 2'd0, 32'h0, 32'h0000_00EF},
    '{1'b0, 3'd5, 2'd1, 32'h0, 32'h0000_EFAB},
    '{1'b0, 3'd7, 2'd1, 32'h0, 32'h0000_00BE},
    '{1'b1, 3'd4, 2'd0, 32'h0000_00FF, 32'h0},
    '{1'b0, 3'd4, 2'd0, 32'h0, 32'h0000_00FC},
    '{1'b1, 3'd0, 2'd0, 32'h0000_00FE, 32'h0},
    '{1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_0008},
    '{1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0, eng_err = 1'b0, dev_irq = 1'b0;
  logic        irq_out, start_req, quiesce_req;
  logic [31:0] cur_ptr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busmaster_regfile i_busmaster_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .eng_busy(eng_busy), .eng_err(eng_err),
    .dev_irq(dev_irq), .irq_out(irq_out), .start_req(start_req),
    .quiesce_req(quiesce_req), .cur_ptr(cur_ptr)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] sz,
                    input logic [31:0] d);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] sz,
                    output logic [31:0] q);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check("R12 start_req", 32'(start_req), 0);
    check("R12 quiesce_req", 32'(quiesce_req), 0);
    check("R12 cur_ptr", cur_ptr, 0);
    check("R12 irq_out", 32'(irq_out), 0);

    // R6 R7 R1 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        wr(VEC[i].a, VEC[i].sz, VEC[i].d);
      end else begin
        rd(VEC[i].a, VEC[i].sz, q);
        check($sformatf("R6/R7/R1 vector %0d", i), q, VEC[i].e);
      end
    end

    // R3 start edge
    wr(3'd0, 2'd0, 32'h01);
    check("R3 start_req pulse", 32'(start_req), 1);
    check("R3 pointer reload", cur_ptr, 32'hBEEF_ABFC);
    @(negedge clk);
    check("R3 start_req one cycle", 32'(start_req), 0);
    rd(3'd2, 2'd0, q);
    check("R3 active set", q, 32'h01);

    // R11 active not writable
    wr(3'd2, 2'd0, 32'h07);
    rd(3'd2, 2'd0, q);
    check("R11 active kept", q, 32'h01);

    // R2 same start bit
    wr(3'd4, 2'd2, 32'h0000_1000);
    wr(3'd0, 2'd0, 32'h09);
    check("R2 no start_req", 32'(start_req), 0);
    check("R2 no reload", cur_ptr, 32'hBEEF_ABFC);
    rd(3'd0, 2'd0, q);
    check("R2 stored", q, 32'h09);

    // R4 deferred stop
    eng_busy = 1'b1;
    wr(3'd0, 2'd0, 32'h00);
    check("R4 quiesce high", 32'(quiesce_req), 1);
    rd(3'd2, 2'd0, q);
    check("R4 active held", q, 32'h01);
    eng_busy = 1'b0;
    @(negedge clk);
    check("R4 quiesce dropped", 32'(quiesce_req), 0);
    rd(3'd2, 2'd0, q);
    check("R4 active cleared", q, 32'h00);

    // R3 restart while active (stop pending)
    eng_busy = 1'b1;
    wr(3'd0, 2'd0, 32'h01);
    check("R3 start_req fresh", 32'(start_req), 1);
    check("R3 reload new base", cur_ptr, 32'h0000_1000);
    wr(3'd0, 2'd0, 32'h00);
    check("R4 pending", 32'(quiesce_req), 1);
    wr(4'd4, 2'd2, 32'h0000_2000);
    wr(3'd0, 2'd0, 32'h01);
    check("R3 no request while active", 32'(start_req), 0);
    check("R3 reload while active", cur_ptr, 32'h0000_2000);
    check("R3 restart cancels stop", 32'(quiesce_req), 0);

    // R5 immediate stop
    eng_busy = 1'b0;
    wr(3'd0, 2'd0, 32'h00);
    check("R5 no quiesce", 32'(quiesce_req), 0);
    rd(3'd2, 2'd0, q);
    check("R5 active cleared", q, 32'h00);

    // R8 R9 interrupt
    dev_irq = 1'b1;
    @(negedge clk);
    check("R8 irq_out rise", 32'(irq_out), 1);
    rd(3'd2, 2'd0, q);
    check("R8 int flag", q, 32'h04);
    dev_irq = 1'b0;
    @(negedge clk);
    check("R9 irq_out fall", 32'(irq_out), 0);
    rd(3'd2, 2'd0, q);
    check("R9 int kept", q, 32'h04);

    // R10 R11 error and clear
    eng_err = 1'b1;
    @(negedge clk);
    eng_err = 1'b0;
    rd(3'd2, 2'd0, q);
    check("R10 error set", q, 32'h06);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, q);
    check("R11 int cleared only", q, 32'h02);
    wr(3'd2, 2'd0, 32'h02);
    rd(3'd2, 2'd0, q);
    check("R11 error cleared", q, 32'h00);

    // R12 reset mid-operation
    wr(3'd0, 2'd0, 32'h09);
    eng_err = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    eng_err = 1'b0;
    rst = 1'b0;
    check("R12 cur_ptr cleared", cur_ptr, 0);
    rd(3'd0, 2'd0, q);
    check("R12 cmd cleared", q, 0);
    rd(3'd2, 2'd0, q);
    check("R12 status cleared", q, 0);
    rd(3'd4, 2'd2, q);
    check("R12 base cleared", q, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  end
endmodule